// File: doc/BRIEF.md
# Palette DAC Register Interface

This block is the register front end of a colour palette. It holds 256 colour entries, each with 8-bit red, green and blue parts, and a small bank of control registers. A host on a 32-bit bus reaches it through three ports that it picks with a select code. The host first writes an index to the address port. It then either streams the red, green and blue parts through the colour port, or reads and writes one control register through the control port. Every payload travels in bits 31:24 of the bus word. The other bits are ignored on writes and read back as zero.

On the video side, an 8-bit pixel value is ANDed with the read mask held in control register 4. The result selects a palette entry, and the 24-bit colour appears on the lookup output one clock later. Control register 6 carries the overlay setting, whose low two bits enable the cursor. Software clears those bits with a read-modify-write through the control port.

Top module: `palette_dac_regs`

## Requirements
- R1: After reset the address pointer is 0, the colour sequence waits for red, read data and lookup output are 0, and control registers 4, 5, 6, 7 hold 0xFF, 0x00, 0x73, 0x00.
- R2: A write with select 0 loads the address pointer from bits 31:24 and restarts the colour sequence at red, even midway through an entry. A read with select 0 returns the pointer in bits 31:24.
- R3: Colour writes (select 1) deliver red, green, then blue. The addressed entry changes only on the blue write, which stores all three parts at once.
- R4: The blue write increments the pointer modulo 256 and returns the sequence to red, so a stream of colour writes fills consecutive entries and wraps from 255 to 0.
- R5: With the pointer on 4 to 7, a control write (select 2) stores bits 31:24 in that register. A control read returns it in bits 31:24 of the read data one cycle later, with bits 23:0 zero.
- R6: With the pointer outside 4 to 7, control writes change no register and control reads return 0.
- R7: The lookup output is the entry at index (pixel AND register 4), with red in bits 23:16, green in 15:8 and blue in 7:0. It is registered, so it follows the pixel input by one cycle.
- R8: Control accesses leave the pointer and the colour sequence unchanged. A read-modify-write of register 6 that clears bits 1:0 turns 0x73 into 0x70.
- R9: A read with select 1 returns 0 and does not advance the colour sequence. Writes with select 3 have no effect. Read data holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busSel | input | 2 | Port select: 0 address, 1 colour, 2 control, 3 none |
| busWrData | input | 32 | Write data; payload in bits 31:24 |
| busRdData | output | 32 | Registered read data; payload in bits 31:24 |
| pixelIdx | input | 8 | Pixel value to look up |
| pixelColor | output | 24 | Looked-up colour {red, green, blue} |

## Verification
A wrong pointer or a slipped colour-sequence step would leave no mark on the bus until a later access. It shows up as colours stored one entry off, or with their parts rotated. The first lookup of the affected entry exposes it two cycles after the blue write, and the next address read returns a wrong value. A corrupted control register shows up on the next control read. If the corruption hits the read mask, it also shows on the very next lookup, because that lookup fetches from the wrong entry. The bench therefore compares both outputs against its model on every clock, so a fault is caught within a cycle or two of the access that exposes it.

// File: rtl/dacregs_pkg.sv
package dacregs_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COLOR = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } busSel_e;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  // control to datapath strobes
  typedef struct packed {
    logic stageRed;
    logic stageGreen;
    logic commit;
    logic ctrlWr;
    logic rdAddr;
    logic rdCtrl;
    logic rdZero;
  } dacStrobe_t;

endpackage

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dacregs_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int CTRL_BASE = 4,
  parameter int CTRL_NUM  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  busSel_e           sel,
  input  logic [LANE_W-1:0] wrLane,
  output logic [LANE_W-1:0] ptr,
  output dacStrobe_t        strb
);

  localparam logic [LANE_W:0] HIT_LO = (LANE_W+1)'(CTRL_BASE);
  localparam logic [LANE_W:0] HIT_HI = (LANE_W+1)'(CTRL_BASE + CTRL_NUM);

  comp_e comp;
  logic  ctrlHit;

  assign ctrlHit = ({1'b0, ptr} >= HIT_LO) && ({1'b0, ptr} < HIT_HI);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (sel)
        SEL_COLOR: begin
          strb.stageRed   = (comp == COMP_RED);
          strb.stageGreen = (comp == COMP_GREEN);
          strb.commit     = (comp == COMP_BLUE);
        end
        SEL_CTRL: strb.ctrlWr = ctrlHit;
        default: ;
      endcase
    end
    if (rdEn) begin
      unique case (sel)
        SEL_ADDR: strb.rdAddr = 1'b1;
        SEL_CTRL: begin
          strb.rdCtrl = ctrlHit;
          strb.rdZero = !ctrlHit;
        end
        default: strb.rdZero = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr  <= '0;
      comp <= COMP_RED;
    end else if (wrEn) begin
      unique case (sel)
        SEL_ADDR: begin
          ptr  <= wrLane;
          comp <= COMP_RED;
        end
        SEL_COLOR: begin
          unique case (comp)
            COMP_RED:   comp <= COMP_GREEN;
            COMP_GREEN: comp <= COMP_BLUE;
            default: begin
              comp <= COMP_RED;
              ptr  <= ptr + 1'b1;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  // R2: address write loads pointer and restarts at red
  a_r2_addr_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_ADDR) |=> (ptr == $past(wrLane)) && (comp == COMP_RED));

  // R4: commit advances pointer by one with wrap
  a_r4_commit_inc: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (ptr == LANE_W'($past(ptr) + 1'b1)) && (comp == COMP_RED));

  // R8: control accesses keep pointer and sequence
  a_r8_ctrl_keeps_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_CTRL) |=> $stable(ptr) && $stable(comp));

  // R9: colour reads without a write keep the sequence
  a_r9_color_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && sel == SEL_COLOR) |=> $stable(comp) && $stable(ptr));

  // R3: at most one colour stage per cycle
  a_r3_one_stage: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stageRed, strb.stageGreen, strb.commit}));

endmodule

// File: rtl/dac_datapath.sv
module dac_datapath
  import dacregs_pkg::*;
#(
  parameter int                          BUS_W     = 32,
  parameter int                          LANE_W    = 8,
  parameter int                          CTRL_BASE = 4,
  parameter int                          CTRL_NUM  = 4,
  parameter int                          MASK_OFS  = 0,
  parameter logic [CTRL_NUM*LANE_W-1:0]  CTRL_INIT = 32'h0073_00FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  dacStrobe_t          strb,
  input  logic [LANE_W-1:0]   ptr,
  input  logic [LANE_W-1:0]   wrLane,
  input  logic [LANE_W-1:0]   pixelIdx,
  output logic [BUS_W-1:0]    rdData,
  output logic [3*LANE_W-1:0] pixelColor
);

  localparam int DEPTH   = 1 << LANE_W;
  localparam int COLOR_W = 3 * LANE_W;
  localparam int PAD_W   = BUS_W - LANE_W;
  localparam int OFS_W   = (CTRL_NUM > 1) ? $clog2(CTRL_NUM) : 1;
  localparam logic [LANE_W-1:0] BASE_V = LANE_W'(CTRL_BASE);

  logic [LANE_W-1:0]  stageR;
  logic [LANE_W-1:0]  stageG;
  logic [COLOR_W-1:0] pal [DEPTH];
  logic [LANE_W-1:0]  ctrlRegs [CTRL_NUM];
  logic [OFS_W-1:0]   ctrlOfs;
  logic [LANE_W-1:0]  readMask;

  assign ctrlOfs  = OFS_W'(ptr - BASE_V);
  assign readMask = ctrlRegs[MASK_OFS];

  // component staging
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageR <= '0;
      stageG <= '0;
    end else begin
      if (strb.stageRed)   stageR <= wrLane;
      if (strb.stageGreen) stageG <= wrLane;
    end
  end

  // palette storage, written whole on the blue step
  always_ff @(posedge clk) begin
    if (strb.commit) pal[ptr] <= {stageR, stageG, wrLane};
  end

  // control register bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CTRL_NUM; i++) ctrlRegs[i] <= CTRL_INIT[i*LANE_W +: LANE_W];
    end else if (strb.ctrlWr) begin
      for (int i = 0; i < CTRL_NUM; i++) begin
        if (ctrlOfs == OFS_W'(i)) ctrlRegs[i] <= wrLane;
      end
    end
  end

  // masked pixel lookup
  always_ff @(posedge clk) begin
    if (!rstN) pixelColor <= '0;
    else       pixelColor <= pal[pixelIdx & readMask];
  end

  // registered bus read data
  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdAddr) rdData <= {ptr, {PAD_W{1'b0}}};
    else if (strb.rdCtrl) rdData <= {ctrlRegs[ctrlOfs], {PAD_W{1'b0}}};
    else if (strb.rdZero) rdData <= '0;
  end

  // R5: low bus bits never carry data
  a_r5_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[PAD_W-1:0] == '0);

  // R9: read data holds when no read strobe
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdAddr || strb.rdCtrl || strb.rdZero) |=> $stable(rdData));

  // R6: bank changes only on an in-range control write
  a_r6_bank_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctrlWr |=> $stable(readMask) && $stable(ctrlRegs[CTRL_NUM-1]));

  // R3: staged red held while not staging red
  a_r3_stage_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.stageRed |=> $stable(stageR));

endmodule

// File: rtl/palette_dac_regs.sv
module palette_dac_regs
  import dacregs_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int LANE_W    = 8,
  parameter int CTRL_BASE = 4,
  parameter int CTRL_NUM  = 4,
  parameter int MASK_OFS  = 0,
  parameter logic [CTRL_NUM*LANE_W-1:0] CTRL_INIT = 32'h0073_00FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [1:0]          busSel,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  input  logic [LANE_W-1:0]   pixelIdx,
  output logic [3*LANE_W-1:0] pixelColor
);

  localparam int PAD_W = BUS_W - LANE_W;

  logic [LANE_W-1:0] wrLane;
  logic [LANE_W-1:0] ptr;
  logic              unusedLowBits;
  dacStrobe_t        strb;

  assign wrLane        = busWrData[BUS_W-1 -: LANE_W];
  assign unusedLowBits = ^busWrData[PAD_W-1:0];

  dac_ctrl #(
    .LANE_W   (LANE_W),
    .CTRL_BASE(CTRL_BASE),
    .CTRL_NUM (CTRL_NUM)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (busWrEn),
    .rdEn  (busRdEn),
    .sel   (busSel_e'(busSel)),
    .wrLane(wrLane),
    .ptr   (ptr),
    .strb  (strb)
  );

  dac_datapath #(
    .BUS_W    (BUS_W),
    .LANE_W   (LANE_W),
    .CTRL_BASE(CTRL_BASE),
    .CTRL_NUM (CTRL_NUM),
    .MASK_OFS (MASK_OFS),
    .CTRL_INIT(CTRL_INIT)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .ptr       (ptr),
    .wrLane    (wrLane),
    .pixelIdx  (pixelIdx),
    .rdData    (busRdData),
    .pixelColor(pixelColor)
  );

endmodule

// File: tb/palette_dac_regs_tb.sv
module palette_dac_regs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busSel = 2'd3;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  pixelIdx = '0;
  logic [23:0] pixelColor;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    running = 1'b0;

  // reference model state
  int          mPal [256];
  bit          mValid [256];
  int          mCtrl [8];
  int          mPtr;
  int          mComp;
  int          mRedHold;
  int          mGreenHold;
  logic [31:0] expRd;
  logic [23:0] expPix;
  bit          expPixValid;

  always #5 clk = ~clk;

  palette_dac_regs u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busSel    (busSel),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pixelIdx  (pixelIdx),
    .pixelColor(pixelColor)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // behavioural model, updated at each rising edge from pre-edge state
  always @(posedge clk) begin
    if (!rstN) begin
      mPtr = 0; mComp = 0; mRedHold = 0; mGreenHold = 0;
      mCtrl[4] = 'hFF; mCtrl[5] = 0; mCtrl[6] = 'h73; mCtrl[7] = 0;
      expRd = '0; expPix = '0; expPixValid = 1'b1;
    end else begin
      int pi;
      pi = int'(pixelIdx) & mCtrl[4];
      expPixValid = mValid[pi];
      expPix = 24'(mPal[pi]);
      if (busRdEn) begin
        if (busSel == 2'd0) expRd = {8'(mPtr), 24'h0};
        else if (busSel == 2'd2 && mPtr >= 4 && mPtr <= 7) expRd = {8'(mCtrl[mPtr]), 24'h0};
        else expRd = '0;
      end
      if (busWrEn) begin
        int v;
        v = int'(busWrData[31:24]);
        if (busSel == 2'd0) begin
          mPtr = v; mComp = 0;
        end else if (busSel == 2'd1) begin
          if (mComp == 0) begin mRedHold = v; mComp = 1; end
          else if (mComp == 1) begin mGreenHold = v; mComp = 2; end
          else begin
            mPal[mPtr] = (mRedHold << 16) | (mGreenHold << 8) | v;
            mValid[mPtr] = 1'b1;
            mPtr = (mPtr + 1) % 256;
            mComp = 0;
          end
        end else if (busSel == 2'd2 && mPtr >= 4 && mPtr <= 7) begin
          mCtrl[mPtr] = v;
        end
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (running && rstN) begin
      check(curReq, busRdData, expRd);
      if (expPixValid) check(curReq, {8'h0, pixelColor}, {8'h0, expPix});
    end
  end

  task automatic drive(bit we, bit re, logic [1:0] s, logic [7:0] lane);
    @(negedge clk);
    busWrEn = we; busRdEn = re; busSel = s;
    busWrData = {lane, 24'hA5C35A};
  endtask

  task automatic idle();
    @(negedge clk);
    busWrEn = 0; busRdEn = 0; busSel = 2'd3; busWrData = '0;
  endtask

  task automatic setAddr(logic [7:0] a); drive(1, 0, 2'd0, a); endtask
  task automatic wrColor(logic [7:0] c); drive(1, 0, 2'd1, c); endtask
  task automatic wrCtrl(logic [7:0] c);  drive(1, 0, 2'd2, c); endtask

  task automatic readReg(logic [1:0] s, output logic [31:0] v);
    drive(0, 1, s, 8'h00);
    @(negedge clk);
    v = busRdData;
    busWrEn = 0; busRdEn = 0; busSel = 2'd3; busWrData = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  rmw;
    for (int i = 0; i < 256; i++) begin mPal[i] = 0; mValid[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;

    // R1 reset state
    curReq = "R1";
    check("R1", busRdData, 32'h0);
    check("R1", {8'h0, pixelColor}, 32'h0);
    readReg(2'd0, v); check("R1", v, 32'h0);
    setAddr(8'd4); readReg(2'd2, v); check("R1", v, 32'hFF00_0000);
    setAddr(8'd5); readReg(2'd2, v); check("R1", v, 32'h0000_0000);
    setAddr(8'd6); readReg(2'd2, v); check("R1", v, 32'h7300_0000);
    setAddr(8'd7); readReg(2'd2, v); check("R1", v, 32'h0000_0000);

    // R3 / R7 single entry and commit on blue
    curReq = "R3";
    setAddr(8'd10); wrColor(8'h11); wrColor(8'h22); wrColor(8'h33);
    pixelIdx = 8'd10;
    idle(); idle();
    check("R7", {8'h0, pixelColor}, 32'h0011_2233);
    setAddr(8'd10); wrColor(8'h44); wrColor(8'h55); idle();
    check("R3", {8'h0, pixelColor}, 32'h0011_2233);
    wrColor(8'h66); idle(); idle();
    check("R3", {8'h0, pixelColor}, 32'h0044_5566);

    // R4 increment and wrap
    curReq = "R4";
    readReg(2'd0, v); check("R4", v, 32'h0B00_0000);
    setAddr(8'd0);
    for (int i = 0; i < 256; i++) begin
      wrColor(8'(i)); wrColor(~8'(i)); wrColor(8'(i + 1));
    end
    readReg(2'd0, v); check("R4", v, 32'h0);
    curReq = "R7";
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); pixelIdx = 8'(p);
    end
    idle(); idle();
    check("R7", {8'h0, pixelColor}, 32'h00FF_0000);

    // R2 address write mid-sequence
    curReq = "R2";
    setAddr(8'd20); wrColor(8'hAA); setAddr(8'd30);
    wrColor(8'h01); wrColor(8'h02); wrColor(8'h03);
    pixelIdx = 8'd30; idle(); idle();
    check("R2", {8'h0, pixelColor}, 32'h0001_0203);
    pixelIdx = 8'd20; idle(); idle();
    check("R2", {8'h0, pixelColor}, 32'h0014_EB15);
    readReg(2'd0, v); check("R2", v, 32'h1F00_0000);

    // R5 / R8 read-modify-write of overlay control
    curReq = "R5";
    setAddr(8'd6); readReg(2'd2, v); check("R5", v, 32'h7300_0000);
    rmw = v[31:24] & 8'hFC;
    wrCtrl(rmw);
    readReg(2'd2, v); check("R8", v, 32'h7000_0000);
    readReg(2'd0, v); check("R8", v, 32'h0600_0000);

    // R9 colour read has no effect on the sequence
    curReq = "R9";
    setAddr(8'd40); wrColor(8'h09);
    readReg(2'd1, v); check("R9", v, 32'h0);
    wrColor(8'h08); wrColor(8'h07);
    pixelIdx = 8'd40; idle(); idle();
    check("R9", {8'h0, pixelColor}, 32'h0009_0807);
    drive(1, 0, 2'd3, 8'h99);
    readReg(2'd0, v); check("R9", v, 32'h2900_0000);

    // R7 read mask
    curReq = "R7";
    setAddr(8'd4); wrCtrl(8'h0F);
    pixelIdx = 8'hF3; idle(); idle();
    check("R7", {8'h0, pixelColor}, 32'h0003_FC04);

    // R6 out-of-range control accesses
    curReq = "R6";
    setAddr(8'd9); wrCtrl(8'h55);
    readReg(2'd2, v); check("R6", v, 32'h0);
    setAddr(8'd3); wrCtrl(8'h66);
    readReg(2'd2, v); check("R6", v, 32'h0);
    setAddr(8'd5); readReg(2'd2, v); check("R6", v, 32'h0);
    setAddr(8'd7); readReg(2'd2, v); check("R6", v, 32'h0);
    setAddr(8'd4); readReg(2'd2, v); check("R6", v, 32'h0F00_0000);

    idle(); idle();
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule